// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Keyed Function Select

This block is an eight-pin general-purpose I/O port behind a simple APB-style slave port with a 4 KB window. Each pin can be an output or an input. Output pins drive the level held in a data register. Input pins are brought through a two-flop synchroniser and copied into that same register. Software reaches the data register through a window in which the address itself selects which bits a read returns and which bits a write may touch. A single access can therefore change any subset of pins without a read-modify-write.

Each pin can raise an interrupt on a rising edge, a falling edge, both edges, a high level or a low level. The block keeps a raw status per pin and a mask that gates the raw status onto one combined interrupt line.

A function-select register can only be changed in the bits allowed by a commit mask. The commit mask can itself only be rewritten after a key value has been written to a lock register. Eight pad-control words are plain storage. A run of read-only identification bytes sits at the top of the window.

Top module: `gpio_lock_port`

## Requirements
- R1: For any word offset below 0x400, bits [9:2] of the address form a mask, and a read returns the data register ANDed with that mask.
- R2: A write below 0x400 changes only the data bits whose mask bit and direction bit (offset 0x400, 1 = output) are both 1. Every other data bit keeps its value.
- R3: `pins_out` carries the data bit on each output pin and a constant 1 on each input pin.
- R4: An input pin's external level reaches the data register three clock edges after it is applied, after two synchroniser flops and the data flop. External levels on output pins never reach the data register.
- R5: Detection is set per pin by three registers: sense at 0x404, both-edges at 0x408 and polarity at 0x40C. Sense = 1 selects level detection, with polarity 1 meaning high and polarity 0 meaning low. Sense = 0 selects edge detection: both-edges = 1 accepts either edge, otherwise polarity 1 means rising and polarity 0 means falling.
- R6: A detected event sets the pin's raw status bit, readable at 0x414. Writing 1s to offset 0x41C clears the matching raw bits. An event in the same cycle as a clear wins, so an active level keeps its bit set. Offset 0x41C reads as 0.
- R7: Masked status at 0x418 is the raw status ANDed with the mask register at 0x410. `irq` is high exactly when any masked bit is 1.
- R8: Writing exactly 0x0ACCE551 to offset 0x520 unlocks the port, and any other value locks it. A read of 0x520 returns 1 when locked and 0 when unlocked. Reset leaves the port locked.
- R9: The commit mask at 0x524 resets to 0xFF and accepts a write only while the port is unlocked.
- R10: A write to the function-select register at 0x420 changes only the bits that are 1 in the commit mask.
- R11: The eight words at 0x500, 0x504 and so on up to 0x51C are read/write storage, each NPINS bits wide.
- R12: Word reads from 0xFD0 to 0xFFC return, in address order, the bytes 00 00 00 00 61 00 18 01 0D F0 05 B1, each zero-extended.
- R13: All other registers reset to 0. Offsets that map to nothing read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW (12) | Byte address within the window |
| pwdata | input | DW (32) | Write data |
| prdata | output | DW (32) | Read data, combinational from the address |
| pins_in | input | NPINS (8) | External pin levels |
| pins_out | output | NPINS (8) | Pin output levels |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its defaults: NPINS = 8, AW = 12, DW = 32 and SYNC_STAGES = 2. With NPINS = 8 every address bit [9:2] takes part in the data mask, so full, partial and single-bit mask patterns can all be applied. The twelve-byte identification run fits below the top of the 4 KB window, and every one of its bytes is read. The two-stage synchroniser gives a fixed three-edge latency from pin to register. Because that latency is fixed, the expected data and status values can be computed for each of the five detection modes.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

  localparam int unsigned MAXW = 32;

  localparam logic [11:0] OFS_DIR    = 12'h400;
  localparam logic [11:0] OFS_SENSE  = 12'h404;
  localparam logic [11:0] OFS_BOTH   = 12'h408;
  localparam logic [11:0] OFS_POL    = 12'h40C;
  localparam logic [11:0] OFS_MASK   = 12'h410;
  localparam logic [11:0] OFS_RAW    = 12'h414;
  localparam logic [11:0] OFS_MST    = 12'h418;
  localparam logic [11:0] OFS_CLR    = 12'h41C;
  localparam logic [11:0] OFS_ALT    = 12'h420;
  localparam logic [11:0] OFS_PAD0   = 12'h500;
  localparam logic [11:0] OFS_LOCK   = 12'h520;
  localparam logic [11:0] OFS_COMMIT = 12'h524;
  localparam logic [11:0] OFS_ID0    = 12'hFD0;
  localparam logic [11:0] OFS_IDLAST = 12'hFFC;

  localparam int unsigned PAD_REGS = 8;
  localparam int unsigned ID_BYTES = 12;
  localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

  typedef enum logic [2:0] {
    DET_FALL, DET_RISE, DET_ANY_EDGE, DET_LOW, DET_HIGH
  } det_mode_e;

  // Keep old bits where sel is 0, take new bits where sel is 1.
  function automatic logic [MAXW-1:0] merge_bits(input logic [MAXW-1:0] old_v,
                                                 input logic [MAXW-1:0] new_v,
                                                 input logic [MAXW-1:0] sel);
    return (old_v & ~sel) | (new_v & sel);
  endfunction

  // Pin level: data bit on outputs, 1 on inputs.
  function automatic logic [MAXW-1:0] drive_level(input logic [MAXW-1:0] data_v,
                                                  input logic [MAXW-1:0] dir_v);
    return (data_v & dir_v) | ~dir_v;
  endfunction

  function automatic det_mode_e det_mode(input logic sense, input logic both,
                                         input logic pol);
    det_mode_e m;
    if (sense)     m = pol ? DET_HIGH : DET_LOW;
    else if (both) m = DET_ANY_EDGE;
    else           m = pol ? DET_RISE : DET_FALL;
    return m;
  endfunction

  function automatic logic pin_event(input det_mode_e m, input logic now_v,
                                     input logic was_v);
    logic r;
    case (m)
      DET_FALL:     r = was_v & ~now_v;
      DET_RISE:     r = ~was_v & now_v;
      DET_ANY_EDGE: r = was_v ^ now_v;
      DET_LOW:      r = ~now_v;
      DET_HIGH:     r = now_v;
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd4:    b = 8'h61;
      4'd6:    b = 8'h18;
      4'd7:    b = 8'h01;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_lock_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign evt[i] = pin_event(det_mode(sense[i], both[i], pol[i]), lvl[i], prev_q[i]);
  end
endmodule

// File: rtl/gpio_key_guard.sv
module gpio_key_guard
  import gpio_lock_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lock,
  input  logic          wr_commit,
  input  logic          wr_alt,
  input  logic [DW-1:0] wdata,
  output logic          locked,
  output logic [W-1:0]  commit,
  output logic [W-1:0]  alt
);
  logic [W-1:0] alt_d;

  assign alt_d = W'(merge_bits(MAXW'(alt), MAXW'(wdata[W-1:0]), MAXW'(commit)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      commit <= '1;
      alt    <= '0;
    end else begin
      if (wr_lock)             locked <= (wdata != DW'(UNLOCK_KEY));
      if (wr_commit && !locked) commit <= wdata[W-1:0];
      if (wr_alt)              alt    <= alt_d;
    end
  end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_lock_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] pins_out,
  output logic             irq
);
  localparam int PW = NPINS;
  localparam logic [AW-1:0] A_DIR    = AW'(OFS_DIR);
  localparam logic [AW-1:0] A_SENSE  = AW'(OFS_SENSE);
  localparam logic [AW-1:0] A_BOTH   = AW'(OFS_BOTH);
  localparam logic [AW-1:0] A_POL    = AW'(OFS_POL);
  localparam logic [AW-1:0] A_MASK   = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_RAW    = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_MST    = AW'(OFS_MST);
  localparam logic [AW-1:0] A_CLR    = AW'(OFS_CLR);
  localparam logic [AW-1:0] A_ALT    = AW'(OFS_ALT);
  localparam logic [AW-1:0] A_PAD0   = AW'(OFS_PAD0);
  localparam logic [AW-1:0] A_PADEND = AW'(OFS_PAD0 + 12'(PAD_REGS * 4));
  localparam logic [AW-1:0] A_LOCK   = AW'(OFS_LOCK);
  localparam logic [AW-1:0] A_COMMIT = AW'(OFS_COMMIT);
  localparam logic [AW-1:0] A_ID0    = AW'(OFS_ID0);
  localparam logic [AW-1:0] A_IDLAST = AW'(OFS_IDLAST);

  // Decoded access
  logic          wr_en;
  logic [AW-1:0] waddr;
  logic          in_data_win, in_pad_win, in_id_win;
  logic [PW-1:0] win_mask;
  logic [2:0]    pad_idx;
  logic [3:0]    id_idx;

  assign wr_en       = psel & penable & pwrite;
  assign waddr       = paddr & ~AW'(3);
  assign in_data_win = (waddr < A_DIR);
  assign in_pad_win  = (waddr >= A_PAD0) && (waddr < A_PADEND);
  assign in_id_win   = (waddr >= A_ID0) && (waddr <= A_IDLAST);
  assign win_mask    = waddr[PW+1:2];
  assign pad_idx     = waddr[4:2];
  assign id_idx      = 4'((waddr - A_ID0) >> 2);

  // Named write strobes
  logic wr_data_win, wr_dir, wr_sense, wr_both, wr_pol, wr_mask, wr_clr;
  logic wr_alt, wr_lock, wr_commit;
  assign wr_data_win = wr_en && in_data_win;
  assign wr_dir      = wr_en && (waddr == A_DIR);
  assign wr_sense    = wr_en && (waddr == A_SENSE);
  assign wr_both     = wr_en && (waddr == A_BOTH);
  assign wr_pol      = wr_en && (waddr == A_POL);
  assign wr_mask     = wr_en && (waddr == A_MASK);
  assign wr_clr      = wr_en && (waddr == A_CLR);
  assign wr_alt      = wr_en && (waddr == A_ALT);
  assign wr_lock     = wr_en && (waddr == A_LOCK);
  assign wr_commit   = wr_en && (waddr == A_COMMIT);

  // State
  logic [PW-1:0] data_q, dir_q, sense_q, both_q, pol_q, mask_q, raw_q;
  logic [PW-1:0] pad_q [PAD_REGS];
  logic [PW-1:0] sync_q, evt;
  logic [PW-1:0] data_d, raw_d, written, clr_bits;
  logic          locked;
  logic [PW-1:0] commit, alt;

  gpio_in_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(pclk), .rst_n(presetn), .d(pins_in), .q(sync_q)
  );

  gpio_evt_detect #(.W(PW)) u_det (
    .clk(pclk), .rst_n(presetn), .lvl(sync_q),
    .sense(sense_q), .both(both_q), .pol(pol_q), .evt(evt)
  );

  gpio_key_guard #(.W(PW), .DW(DW)) u_guard (
    .clk(pclk), .rst_n(presetn), .wr_lock(wr_lock), .wr_commit(wr_commit),
    .wr_alt(wr_alt), .wdata(pwdata), .locked(locked), .commit(commit), .alt(alt)
  );

  // Output bits take the masked write; input bits follow the synchroniser.
  assign written  = PW'(merge_bits(MAXW'(data_q), MAXW'(pwdata[PW-1:0]),
                                   wr_data_win ? MAXW'(win_mask) : '0));
  assign data_d   = PW'(merge_bits(MAXW'(sync_q), MAXW'(written), MAXW'(dir_q)));
  assign clr_bits = wr_clr ? pwdata[PW-1:0] : '0;
  assign raw_d    = (raw_q & ~clr_bits) | evt;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      raw_q   <= '0;
    end else begin
      data_q <= data_d;
      raw_q  <= raw_d;
      if (wr_dir)   dir_q   <= pwdata[PW-1:0];
      if (wr_sense) sense_q <= pwdata[PW-1:0];
      if (wr_both)  both_q  <= pwdata[PW-1:0];
      if (wr_pol)   pol_q   <= pwdata[PW-1:0];
      if (wr_mask)  mask_q  <= pwdata[PW-1:0];
    end
  end

  for (genvar k = 0; k < PAD_REGS; k++) begin : g_pad
    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn)                                   pad_q[k] <= '0;
      else if (wr_en && in_pad_win && pad_idx == 3'(k)) pad_q[k] <= pwdata[PW-1:0];
    end
  end

  assign pins_out = PW'(drive_level(MAXW'(data_q), MAXW'(dir_q)));
  assign irq      = |(raw_q & mask_q);

  always_comb begin
    prdata = '0;
    if (in_data_win)     prdata = DW'(data_q & win_mask);
    else if (in_pad_win) prdata = DW'(pad_q[pad_idx]);
    else if (in_id_win)  prdata = DW'(id_byte(id_idx));
    else begin
      case (waddr)
        A_DIR:    prdata = DW'(dir_q);
        A_SENSE:  prdata = DW'(sense_q);
        A_BOTH:   prdata = DW'(both_q);
        A_POL:    prdata = DW'(pol_q);
        A_MASK:   prdata = DW'(mask_q);
        A_RAW:    prdata = DW'(raw_q);
        A_MST:    prdata = DW'(raw_q & mask_q);
        A_ALT:    prdata = DW'(alt);
        A_LOCK:   prdata = DW'(locked);
        A_COMMIT: prdata = DW'(commit);
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_lock_port_chk.sv
module gpio_lock_port_chk
  import gpio_lock_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_data_win,
  input logic          wr_lock,
  input logic          wr_alt,
  input logic [DW-1:0] pwdata,
  input logic          locked,
  input logic [W-1:0]  commit,
  input logic [W-1:0]  alt,
  input logic [W-1:0]  data_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  sync_q,
  input logic [W-1:0]  raw_q,
  input logic [W-1:0]  evt
);
  assert_out_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_win |=> ((data_q ^ $past(data_q)) & $past(dir_q)) == '0);

  assert_in_bits_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((data_q ^ $past(sync_q)) & ~$past(dir_q)) == '0);

  assert_event_sets_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (raw_q & $past(evt)) == $past(evt));

  assert_key_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && pwdata == DW'(UNLOCK_KEY)) |=> !locked);

  assert_other_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && pwdata != DW'(UNLOCK_KEY)) |=> locked);

  assert_commit_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(commit));

  assert_alt_outside_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alt |=> ((alt ^ $past(alt)) & ~$past(commit)) == '0);

  assert_alt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_alt |=> $stable(alt));
endmodule

bind gpio_lock_port gpio_lock_port_chk #(.W(NPINS), .DW(DW)) u_chk (
  .clk(pclk), .rst_n(presetn), .wr_data_win(wr_data_win), .wr_lock(wr_lock),
  .wr_alt(wr_alt), .pwdata(pwdata), .locked(locked), .commit(commit), .alt(alt),
  .data_q(data_q), .dir_q(dir_q), .sync_q(sync_q), .raw_q(raw_q), .evt(evt)
);

// File: tb/gpio_lock_port_tb.sv
module gpio_lock_port_tb;
  localparam logic [11:0] DIR = 12'h400, SNS = 12'h404, BTH = 12'h408, POL = 12'h40C;
  localparam logic [11:0] MSK = 12'h410, RAW = 12'h414, MST = 12'h418, CLR = 12'h41C;
  localparam logic [11:0] ALT = 12'h420, PAD = 12'h500, LCK = 12'h520, CMT = 12'h524;
  localparam logic [11:0] IDB = 12'hFD0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  pins_in = 8'h30;
  logic [7:0]  pins_out;
  logic        irq;

  always #5 clk = ~clk;

  gpio_lock_port u_dut (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pins_in(pins_in),
    .pins_out(pins_out), .irq(irq)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per completed read access.
  always @(negedge clk) begin
    logic [31:0] e;
    string t;
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        check("monitor-underflow", 32'd1, 32'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, prdata, e);
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); #1;
    penable = 1'b1;
    @(negedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk); #1;
    penable = 1'b1;
    @(negedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] idv [12];
    idv = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // Reset state: R13, R8, R9, R3, R7
    check("R3 reset pins_out", {24'd0, pins_out}, 32'hFF);
    check("R7 reset irq", {31'd0, irq}, 32'd0);
    bus_read(DIR, 32'h0,  "R13 reset dir");
    bus_read(ALT, 32'h0,  "R13 reset alt");
    bus_read(RAW, 32'h0,  "R13 reset raw");
    bus_read(LCK, 32'h1,  "R8 reset locked");
    bus_read(CMT, 32'hFF, "R9 reset commit");

    // Identification bytes: R12
    for (int i = 0; i < 12; i++)
      bus_read(IDB + 12'(i * 4), {24'd0, idv[i]}, $sformatf("R12 id byte %0d", i));

    // Data window: R1, R2, R3, R4
    bus_write(DIR, 32'h0F);
    bus_write(12'h3FC, 32'hA5);
    check("R3 pins_out after write", {24'd0, pins_out}, 32'hF5);
    bus_read(12'h3FC, 32'h35, "R1 full mask read");
    bus_write(12'h00C, 32'h00);
    check("R2 masked write pins_out", {24'd0, pins_out}, 32'hF4);
    bus_read(12'h044, 32'h10, "R1 sparse mask read");
    bus_read(12'h000, 32'h00, "R1 empty mask read");
    pins_in = 8'h3F;
    settle();
    bus_read(12'h3FC, 32'h34, "R4 output pins ignore input");
    pins_in = 8'h5F;
    settle();
    bus_read(12'h3FC, 32'h54, "R4 input pins follow pins_in");
    bus_write(12'h3FC, 32'hC3);
    bus_read(12'h3FC, 32'h53, "R2 input bits not written");
    check("R3 pins_out mixed", {24'd0, pins_out}, 32'hF3);

    // Lock, commit, function select: R8, R9, R10
    bus_write(CMT, 32'h00);
    bus_read(CMT, 32'hFF, "R9 commit locked write ignored");
    bus_write(ALT, 32'hFF);
    bus_read(ALT, 32'hFF, "R10 full commit write");
    bus_write(LCK, 32'h0ACCE551);
    bus_read(LCK, 32'h0, "R8 key unlocks");
    bus_write(CMT, 32'h0F);
    bus_read(CMT, 32'h0F, "R9 commit unlocked write");
    bus_write(ALT, 32'h00);
    bus_read(ALT, 32'hF0, "R10 partial commit write");
    bus_write(LCK, 32'h1ACCE551);
    bus_read(LCK, 32'h1, "R8 near-key locks");
    bus_write(CMT, 32'hFF);
    bus_read(CMT, 32'h0F, "R9 relocked write ignored");

    // Pad storage: R11
    for (int k = 0; k < 8; k++) bus_write(PAD + 12'(k * 4), 32'(8'h11 * (k + 1)));
    for (int k = 0; k < 8; k++)
      bus_read(PAD + 12'(k * 4), 32'(8'h11 * (k + 1)), $sformatf("R11 pad word %0d", k));

    // Unmapped and write-only: R13, R6
    bus_write(12'h428, 32'hFF);
    bus_read(12'h428, 32'h0, "R13 unmapped read");
    bus_read(12'h600, 32'h0, "R13 unmapped gap read");
    bus_read(12'hFCC, 32'h0, "R13 below id read");
    bus_read(CLR, 32'h0, "R6 clear reads zero");

    // Interrupts: R5, R6, R7
    bus_write(DIR, 32'h00);
    pins_in = 8'h12;
    settle();
    bus_write(MSK, 32'h00);
    bus_write(SNS, 32'h18);
    bus_write(BTH, 32'h04);
    bus_write(POL, 32'h09);
    bus_write(CLR, 32'hFF);
    bus_read(RAW, 32'h00, "R6 cleared start");
    pins_in = 8'h13; settle();
    bus_read(RAW, 32'h01, "R5 rising edge");
    bus_read(MST, 32'h00, "R7 masked off");
    check("R7 irq masked off", {31'd0, irq}, 32'd0);
    bus_write(MSK, 32'h01);
    bus_read(MST, 32'h01, "R7 masked on");
    check("R7 irq raised", {31'd0, irq}, 32'd1);
    bus_write(CLR, 32'h01);
    bus_read(RAW, 32'h00, "R6 write-one clear");
    check("R7 irq dropped", {31'd0, irq}, 32'd0);
    pins_in = 8'h11; settle();
    bus_read(RAW, 32'h02, "R5 falling edge");
    bus_write(CLR, 32'h02);
    pins_in = 8'h15; settle();
    bus_read(RAW, 32'h04, "R5 both edges rise");
    bus_write(CLR, 32'h04);
    pins_in = 8'h11; settle();
    bus_read(RAW, 32'h04, "R5 both edges fall");
    bus_write(CLR, 32'h04);
    pins_in = 8'h10; settle();
    bus_read(RAW, 32'h00, "R5 rising-only ignores fall");
    pins_in = 8'h18; settle();
    bus_read(RAW, 32'h08, "R5 high level");
    bus_write(CLR, 32'h08);
    bus_read(RAW, 32'h08, "R6 active level resets bit");
    pins_in = 8'h10; settle();
    bus_write(CLR, 32'h08);
    bus_read(RAW, 32'h00, "R6 clear after level gone");
    bus_write(MSK, 32'hFF);
    pins_in = 8'h00; settle();
    bus_read(RAW, 32'h10, "R5 low level");
    bus_read(MST, 32'h10, "R7 masked low level");
    check("R7 irq on low level", {31'd0, irq}, 32'd1);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("monitor-drain", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule